// File: doc/BRIEF.md
# Register-Mapped Countdown Timer

This block is a general-purpose timer that sits on a simple word-wide register bus. The bus carries a byte address, a write strobe, write data and read data. Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high. Software stores a 32-bit interval, chooses one-shot or periodic operation, and sets the enable bit. The block then counts the interval down on every clock cycle.

Each timeout does three things. It sets a sticky raw status flag. It can drive a single-cycle trigger pulse to neighbouring logic. In periodic mode it reloads the count, and in one-shot mode it clears its own enable bit. A registered level interrupt is raised while any raw status bit is also set in the mask. Software acknowledges status bits by writing ones to a write-only clear register.

The counting engine runs only when the configuration register holds 0, which selects the 32-bit countdown. A configuration of 4 or more only changes how the load and match registers are written and read back.

Top module: `cdtimer`

## Requirements
- R1: After reset every register reads 0, and `irq_o` and `trig_o` are low.
- R2: Offsets 0x00 (config), 0x04 (mode A) and 0x08 (mode B) store and return the full 32-bit word. Offset 0x0C (control) does the same. Offset 0x20 returns raw status AND mask.
- R3: Load (0x28) and match (0x30) are each split into a low half (bits 15:0) and a high half (bits 31:16). While config is below 4, a write stores both halves and a read returns them combined. At config 4 or above, a write stores only the low half and a read returns only the low half.
- R4: A write that changes control bit 0 from 0 to 1 loads the count from the load register. A load of 0 counts as 1. The timeout then happens on the L-th rising edge after the write edge. Counting happens only while config is 0.
- R5: Each timeout sets raw status bit 0 (offset 0x1C). Bus writes to offset 0x1C are ignored.
- R6: When control bit 5 is 1, `trig_o` is high for exactly the one cycle that follows a timeout edge. When control bit 5 is 0, `trig_o` stays low.
- R7: With mode A bit 0 set to 1 (one-shot), the timeout clears control bit 0 and the other control bits keep their values. With mode A bit 0 at 0 (periodic), the count reloads and timeouts repeat every L cycles.
- R8: A write that clears control bit 0 stops counting, and no later timeout occurs.
- R9: A write to the mask register (0x18) keeps only bits 0x77. `irq_o` follows (raw status AND mask) != 0 one cycle later.
- R10: A write to the clear register (0x24) clears each raw status bit written as 1. The clear register reads 0. A timeout in the same cycle as a clear leaves the status bit set.
- R11: Reads at unmapped offsets return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Registered level interrupt |
| trig_o | output | 1 | One-cycle timeout trigger pulse |

## Verification
The bench sweeps one-shot intervals from 1 to 10 and several periodic intervals. On every cycle it compares the position of the trigger pulse with the interval, so an off-by-one counter that times out one cycle early or late is caught at once. It covers the following corner cases:
- A load of 0 must behave as 1. A design that wraps to the maximum count would fall silent.
- A clear written in the same cycle as a timeout must lose to the timeout. A design with the wrong priority would drop the event.
- A config of 4 must cut the load read-back to its low half and protect the stored high half. A design that decoded this wrongly would corrupt the later 32-bit interval.
- The interrupt must lag a mask or status change by exactly one cycle, and the one-shot mode must clear only the enable bit. A design that dropped the trigger enable along with it would read back a different control word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register byte offsets
  localparam int unsigned OFF_CFG   = 'h00;
  localparam int unsigned OFF_MODEA = 'h04;
  localparam int unsigned OFF_MODEB = 'h08;
  localparam int unsigned OFF_CTRL  = 'h0C;
  localparam int unsigned OFF_MASK  = 'h18;
  localparam int unsigned OFF_RAW   = 'h1C;
  localparam int unsigned OFF_MSKD  = 'h20;
  localparam int unsigned OFF_CLR   = 'h24;
  localparam int unsigned OFF_LOAD  = 'h28;
  localparam int unsigned OFF_MATCH = 'h30;

  // Field positions
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_TRIG_BIT = 5;
  localparam int unsigned MODE_ONE_BIT  = 0;
  localparam int unsigned STAT_TMO_BIT  = 0;

  localparam logic [31:0] MASK_KEEP     = 32'h0000_0077;
  localparam int unsigned CFG_SPLIT_MIN = 4;
endpackage

// File: rtl/tmr_split_reg.sv
module tmr_split_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] read_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] lo_q, lo_d;
  logic [HALF_W-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_en) begin
      lo_d = wdata[HALF_W-1:0];
      if (wide) begin
        hi_d = wdata[DATA_W-1:HALF_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign read_o = wide ? {hi_q, lo_q} : {{HALF_W{1'b0}}, lo_q};
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmo_i,
  input  logic              stop_i,
  output logic              start_o,
  output logic              run_o,
  output logic              trig_en_o,
  output logic              oneshot_o,
  output logic              cfg_cd_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int unsigned NSPLIT = 2;

  logic [DATA_W-1:0] cfg_q, cfg_d, modea_q, modea_d, modeb_q, modeb_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d, mask_q, mask_d, stat_q, stat_d;
  logic              wr_cfg, wr_modea, wr_modeb, wr_ctrl, wr_mask, wr_clr;
  logic              wide;
  logic [NSPLIT-1:0] split_we;
  logic [DATA_W-1:0] split_rd [NSPLIT];

  assign wr_cfg   = bus_we && (bus_addr == ADDR_W'(OFF_CFG));
  assign wr_modea = bus_we && (bus_addr == ADDR_W'(OFF_MODEA));
  assign wr_modeb = bus_we && (bus_addr == ADDR_W'(OFF_MODEB));
  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_mask  = bus_we && (bus_addr == ADDR_W'(OFF_MASK));
  assign wr_clr   = bus_we && (bus_addr == ADDR_W'(OFF_CLR));
  assign split_we[0] = bus_we && (bus_addr == ADDR_W'(OFF_LOAD));
  assign split_we[1] = bus_we && (bus_addr == ADDR_W'(OFF_MATCH));
  assign wide = (cfg_q < DATA_W'(CFG_SPLIT_MIN));

  // Load (index 0) and match (index 1) share the split-half layout
  for (genvar g = 0; g < NSPLIT; g++) begin : g_split
    tmr_split_reg #(.DATA_W(DATA_W)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (split_we[g]),
      .wide   (wide),
      .wdata  (bus_wdata),
      .read_o (split_rd[g])
    );
  end

  always_comb begin
    cfg_d   = wr_cfg   ? bus_wdata : cfg_q;
    modea_d = wr_modea ? bus_wdata : modea_q;
    modeb_d = wr_modeb ? bus_wdata : modeb_q;
    mask_d  = wr_mask  ? (bus_wdata & MASK_KEEP[DATA_W-1:0]) : mask_q;

    ctrl_d = ctrl_q;
    if (stop_i) begin
      ctrl_d[CTRL_RUN_BIT] = 1'b0;
    end
    if (wr_ctrl) begin
      ctrl_d = bus_wdata;
    end

    stat_d = stat_q;
    if (wr_clr) begin
      stat_d = stat_q & ~bus_wdata;
    end
    if (tmo_i) begin
      stat_d[STAT_TMO_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      modea_q <= '0;
      modeb_q <= '0;
      ctrl_q  <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
    end else begin
      cfg_q   <= cfg_d;
      modea_q <= modea_d;
      modeb_q <= modeb_d;
      ctrl_q  <= ctrl_d;
      mask_q  <= mask_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CFG):   bus_rdata = cfg_q;
      ADDR_W'(OFF_MODEA): bus_rdata = modea_q;
      ADDR_W'(OFF_MODEB): bus_rdata = modeb_q;
      ADDR_W'(OFF_CTRL):  bus_rdata = ctrl_q;
      ADDR_W'(OFF_MASK):  bus_rdata = mask_q;
      ADDR_W'(OFF_RAW):   bus_rdata = stat_q;
      ADDR_W'(OFF_MSKD):  bus_rdata = stat_q & mask_q;
      ADDR_W'(OFF_LOAD):  bus_rdata = split_rd[0];
      ADDR_W'(OFF_MATCH): bus_rdata = split_rd[1];
      default:            bus_rdata = '0;
    endcase
  end

  assign start_o   = wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !ctrl_q[CTRL_RUN_BIT];
  assign run_o     = ctrl_q[CTRL_RUN_BIT];
  assign trig_en_o = ctrl_q[CTRL_TRIG_BIT];
  assign oneshot_o = modea_q[MODE_ONE_BIT];
  assign cfg_cd_o  = (cfg_q == '0);
  assign load_o    = split_rd[0];
  assign mask_o    = mask_q;
  assign status_o  = stat_q;
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             oneshot_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             tmo_o,
  output logic             stop_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, eff_load;
  logic             tmo;

  assign eff_load = (load_i == '0) ? ONE : load_i;
  assign tmo      = run_i && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = eff_load;
    end else if (run_i) begin
      cnt_d = tmo ? eff_load : (cnt_q - ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tmo_o   = tmo;
  assign stop_o  = tmo && oneshot_i;
  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_i,
  input  logic              trig_en_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              irq_o,
  output logic              trig_o
);
  logic irq_q, irq_d, trig_q, trig_d;

  always_comb begin
    irq_d  = |(status_i & mask_i);
    trig_d = tmo_i && trig_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      trig_q <= trig_d;
    end
  end

  assign irq_o  = irq_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              trig_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              start, run, trig_en, oneshot, cfg_cd, tmo, stop;
  logic [DATA_W-1:0] load, mask, status, count;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  tmr_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmo_i     (tmo),
    .stop_i    (stop),
    .start_o   (start),
    .run_o     (run),
    .trig_en_o (trig_en),
    .oneshot_o (oneshot),
    .cfg_cd_o  (cfg_cd),
    .load_o    (load),
    .mask_o    (mask),
    .status_o  (status)
  );

  tmr_countdown #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start),
    .run_i     (run && cfg_cd),
    .oneshot_i (oneshot),
    .load_i    (load),
    .tmo_o     (tmo),
    .stop_o    (stop),
    .count_o   (count)
  );

  tmr_irq_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tmo_i     (tmo),
    .trig_en_i (trig_en),
    .status_i  (status),
    .mask_i    (mask),
    .irq_o     (irq_o),
    .trig_o    (trig_o)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              trig_o,
  input logic              run,
  input logic              trig_en,
  input logic              oneshot,
  input logic              cfg_cd,
  input logic              tmo,
  input logic [DATA_W-1:0] mask,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] count
);
  logic mapped, ctrl_wr;

  always_comb begin
    mapped = (bus_addr == ADDR_W'(OFF_CFG))  || (bus_addr == ADDR_W'(OFF_MODEA)) ||
             (bus_addr == ADDR_W'(OFF_MODEB)) || (bus_addr == ADDR_W'(OFF_CTRL))  ||
             (bus_addr == ADDR_W'(OFF_MASK))  || (bus_addr == ADDR_W'(OFF_RAW))   ||
             (bus_addr == ADDR_W'(OFF_MSKD))  || (bus_addr == ADDR_W'(OFF_CLR))   ||
             (bus_addr == ADDR_W'(OFF_LOAD))  || (bus_addr == ADDR_W'(OFF_MATCH));
    ctrl_wr = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  end

  // R9
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~MASK_KEEP[DATA_W-1:0]) == '0);

  // R10
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_CLR)) |-> (bus_rdata == '0));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0));

  // R6
  trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(trig_en));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && oneshot && !ctrl_wr) |=> !run);

  // R4
  run_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (count != '0));

  // R5
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[STAT_TMO_BIT]) |-> $past(run && cfg_cd));
endmodule

bind cdtimer tmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .trig_o    (trig_o),
  .run       (run),
  .trig_en   (trig_en),
  .oneshot   (oneshot),
  .cfg_cd    (cfg_cd),
  .tmo       (tmo),
  .mask      (mask),
  .status    (status),
  .count     (count)
);

// File: tb/test_cdtimer.sv
`timescale 1ns/100ps
module test_cdtimer;
  localparam logic [7:0] A_CFG = 8'h00, A_MA = 8'h04, A_MB = 8'h08, A_CTRL = 8'h0C;
  localparam logic [7:0] A_MASK = 8'h18, A_RAW = 8'h1C, A_MSKD = 8'h20, A_CLR = 8'h24;
  localparam logic [7:0] A_LOAD = 8'h28, A_MATCH = 8'h30, A_IDLE = 8'hFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = A_IDLE;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, trig_o;
  int          nchk = 0;
  int          nerr = 0;

  always #2.5 clk = ~clk;

  cdtimer i_cdtimer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .trig_o(trig_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = A_IDLE;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
    bus_addr = A_IDLE;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned period;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 trig", {31'b0, trig_o}, 0);
    foreach (rst_list[i]) begin
      rd(rst_list[i], v); chk("R1 reg", v, 0);
    end

    // R2 plain registers
    wr(A_CFG, 32'h0000_0005); rd(A_CFG, v); chk("R2 cfg", v, 32'h5);
    wr(A_MA, 32'hA5A5_0002); rd(A_MA, v); chk("R2 modeA", v, 32'hA5A5_0002);
    wr(A_MB, 32'h0000_001A); rd(A_MB, v); chk("R2 modeB", v, 32'h1A);
    wr(A_CTRL, 32'h0000_0C20); rd(A_CTRL, v); chk("R2 ctrl", v, 32'hC20);
    wr(A_CTRL, 0); wr(A_CFG, 0);

    // R3 split load and match
    wr(A_LOAD, 32'h1234_5678); rd(A_LOAD, v); chk("R3 load wide", v, 32'h1234_5678);
    wr(A_MATCH, 32'hCAFE_0001); rd(A_MATCH, v); chk("R3 match wide", v, 32'hCAFE_0001);
    wr(A_CFG, 4);
    wr(A_LOAD, 32'h0000_ABCD); rd(A_LOAD, v); chk("R3 load narrow", v, 32'h0000_ABCD);
    wr(A_MATCH, 32'hFFFF_0002); rd(A_MATCH, v); chk("R3 match narrow", v, 32'h0000_0002);
    wr(A_CFG, 0);
    rd(A_LOAD, v); chk("R3 load high kept", v, 32'h1234_ABCD);
    rd(A_MATCH, v); chk("R3 match high kept", v, 32'hCAFE_0002);

    // R11 unmapped writes and reads; R5 raw status write ignored
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    wr(A_RAW, 32'hFFFF_FFFF); wr(A_MSKD, 32'hFFFF_FFFF);
    foreach (unm_list[i]) begin
      rd(unm_list[i], v); chk("R11 unmapped read", v, 0);
    end
    rd(A_CFG, v); chk("R11 cfg untouched", v, 0);
    rd(A_CTRL, v); chk("R11 ctrl untouched", v, 0);
    rd(A_MASK, v); chk("R11 mask untouched", v, 0);
    rd(A_LOAD, v); chk("R11 load untouched", v, 32'h1234_ABCD);
    rd(A_RAW, v); chk("R5 raw write ignored", v, 0);
    chk("R11 irq low", {31'b0, irq_o}, 0);

    // R9 mask filtering
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, v); chk("R9 mask keep", v, 32'h77);
    wr(A_MASK, 32'h1);

    // R4 R5 R6 R7 one-shot sweep, ctrl bit0 enable, bit5 trigger, mode A bit0 one-shot
    wr(A_MA, 1);
    for (int L = 1; L <= 10; L++) begin
      wr(A_LOAD, L);
      wr(A_CLR, 1);
      wr(A_CTRL, 32'h21);
      for (int k = 1; k <= L + 1; k++) begin
        step();
        if (k < L) chk("R4 no early trig", {31'b0, trig_o}, 0);
        if (k == L) begin
          chk("R4 R6 trig at L", {31'b0, trig_o}, 1);
          chk("R9 irq lags status", {31'b0, irq_o}, 0);
        end
        if (k == L + 1) begin
          chk("R6 trig one cycle", {31'b0, trig_o}, 0);
          chk("R9 irq one cycle later", {31'b0, irq_o}, 1);
        end
      end
      rd(A_CTRL, v); chk("R7 one-shot clears enable only", v, 32'h20);
      rd(A_RAW, v); chk("R5 raw status set", v, 1);
      rd(A_MSKD, v); chk("R2 masked status", v, 1);
    end

    // R10 clear semantics and R9 irq falling
    wr(A_CLR, 32'h2); rd(A_RAW, v); chk("R10 other bit clear keeps bit0", v, 1);
    wr(A_CLR, 0); rd(A_RAW, v); chk("R10 zero clear keeps bit0", v, 1);
    rd(A_CLR, v); chk("R10 clear reads zero", v, 0);
    wr(A_MASK, 32'h76);
    chk("R9 irq before mask lag", {31'b0, irq_o}, 1);
    step(); chk("R9 irq after mask drop", {31'b0, irq_o}, 0);
    rd(A_MSKD, v); chk("R2 masked zero", v, 0);
    wr(A_MASK, 1); step();
    chk("R9 irq back", {31'b0, irq_o}, 1);
    wr(A_CLR, 1);
    chk("R10 irq lags clear", {31'b0, irq_o}, 1);
    step(); chk("R10 irq after clear", {31'b0, irq_o}, 0);

    // R7 periodic sweep and R8 stop
    wr(A_MA, 0);
    foreach (per_list[i]) begin
      period = per_list[i];
      wr(A_LOAD, period);
      wr(A_CTRL, 32'h21);
      for (int k = 1; k <= 3 * int'(period); k++) begin
        step();
        chk("R7 periodic trig", {31'b0, trig_o}, (k % int'(period) == 0) ? 1 : 0);
      end
      wr(A_CTRL, 32'h20);
      for (int k = 1; k <= 2 * int'(period) + 4; k++) begin
        step();
        chk("R8 stopped no trig", {31'b0, trig_o}, 0);
      end
    end

    // R4 load of zero behaves as one
    wr(A_LOAD, 0);
    wr(A_CTRL, 32'h21);
    for (int k = 1; k <= 4; k++) begin
      step(); chk("R4 zero load trig each cycle", {31'b0, trig_o}, 1);
    end
    wr(A_CTRL, 0);

    // R6 trigger disabled
    wr(A_MA, 1); wr(A_LOAD, 4); wr(A_CLR, 1);
    wr(A_CTRL, 32'h01);
    for (int k = 1; k <= 5; k++) begin
      step(); chk("R6 no trig when disabled", {31'b0, trig_o}, 0);
    end
    rd(A_RAW, v); chk("R6 status still set", v, 1);
    rd(A_CTRL, v); chk("R7 enable cleared", v, 0);

    // R4 nonzero config does not count
    wr(A_CFG, 1); wr(A_CLR, 1); wr(A_LOAD, 3);
    wr(A_CTRL, 32'h21);
    for (int k = 1; k <= 10; k++) begin
      step(); chk("R4 cfg1 no count", {31'b0, trig_o}, 0);
    end
    rd(A_RAW, v); chk("R4 cfg1 no status", v, 0);
    wr(A_CTRL, 0); wr(A_CFG, 0);

    // R10 timeout wins over clear in the same cycle
    wr(A_MA, 0); wr(A_LOAD, 4); wr(A_CLR, 1);
    wr(A_CTRL, 32'h21);
    repeat (3) step();
    wr(A_CLR, 1);
    chk("R10 trig at same edge", {31'b0, trig_o}, 1);
    rd(A_RAW, v); chk("R10 timeout beats clear", v, 1);
    wr(A_CLR, 1);
    rd(A_RAW, v); chk("R10 clear between timeouts", v, 0);
    wr(A_CTRL, 0);

    summary();
    $finish;
  end

  logic [7:0] rst_list [10] = '{A_CFG, A_MA, A_MB, A_CTRL, A_MASK, A_RAW, A_MSKD, A_CLR, A_LOAD, A_MATCH};
  logic [7:0] unm_list [7]  = '{8'h10, 8'h14, 8'h2C, 8'h34, 8'h40, 8'h48, A_IDLE};
  int unsigned per_list [5] = '{1, 2, 3, 5, 7};
endmodule